// File: doc/BRIEF.md
# Element Type Converter with Single-Precision Pivot

This block turns one data element from a source number format into a destination number format. Every conversion takes the same route. The source word is first widened to IEEE single precision (FP32), and that intermediate value is then narrowed to the destination format. There is no dedicated path for any particular pair of formats. The widening step is exact for every float source. Rounding happens once, in the narrowing step, except for integer sources wider than 24 significant bits.

The caller supplies a source type code, a destination type code and a 32-bit word, and marks them with a valid strobe. Exactly three clock edges later the converted word appears with its own strobe. Results narrower than 32 bits are zero-extended. The pipeline accepts a new element on every cycle and has no stall input. A source and destination code that are equal give an untouched copy of the input word.

Top module: `dtype_pivot_conv`

## Requirements
- R1: Type codes are: 0x2 signed 8-bit, 0x3 unsigned 8-bit, 0x4 signed 16-bit, 0x5 unsigned 16-bit, 0x6 BF16, 0x7 FP16, 0x8 signed 32-bit, 0x9 unsigned 32-bit, 0xA FP32, 0xD FP8 with 3 exponent and 4 mantissa bits (bias 3), 0xE FP8 with 4 exponent and 3 mantissa bits (bias 7), and 0xF FP8 with 5 exponent and 2 mantissa bits (bias 15). All three FP8 formats reserve their all-ones exponent for infinity and NaN. Each format occupies the low bits of the word, with its sign in the top bit of its width.
- R2: A valid_i sampled at a rising edge gives valid_o high after the third rising edge, counting the sampling edge, and for that one cycle only. Reset clears valid_o and data_o at once.
- R3: When the source and destination codes are equal, data_o equals the full 32-bit data_i, with no NaN canonicalisation.
- R4: Integer sources convert to the exact value, rounded to nearest with ties to even where more than 24 significant bits are present. Bits of data_i above the source width are ignored.
- R5: Integer destinations take the float value rounded toward zero.
- R6: Integer destinations saturate at their minimum and maximum. A negative value into an unsigned destination gives 0, a NaN gives 0, and an infinity saturates.
- R7: Float destinations round to nearest, with ties to even.
- R8: A finite value whose rounded magnitude exceeds the destination's largest finite value gives that largest finite value with the original sign. An infinity stays infinite in BF16 and FP16, and becomes the signed largest finite value in the FP8 formats.
- R9: A NaN of any float format gives the canonical quiet NaN of the destination: sign 0, exponent all ones, mantissa MSB only set. For FP16 this is 0x7E00, for BF16 0x7FC0, for FP32 0x7FC00000, and for the FP8 formats 0x78, 0x7C and 0x7E (codes 0xD, 0xE, 0xF).
- R10: Subnormal sources widen exactly. Values below the destination's normal range round to a subnormal or to a zero that keeps the sign.
- R11: Conversions between two non-FP32 float formats give the same result as rounding the exact source value once into the destination.
- R12: Destinations narrower than 32 bits are zero-extended in data_o.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| valid_i | input | 1 | Input element strobe |
| src_type_i | input | 4 | Source type code |
| dst_type_i | input | 4 | Destination type code |
| data_i | input | 32 | Source word, low-aligned |
| valid_o | output | 1 | Result strobe |
| data_o | output | 32 | Converted word, zero-extended |

## Verification
Round-to-nearest and overflow saturation can act on the same element. This happens when the round-up carry spills into the exponent and lands on the reserved exponent. FP32 65520 converted to FP16 provokes it, and the check expects 0x7BFF rather than infinity. A second overlap is across the pipeline. The vector table streams one element per cycle, so equal-code bypass words and converted words occupy neighbouring stages at the same time. Each output is compared with its own row exactly three edges after it entered.

// File: rtl/dtype_pivot_pkg.sv
package dtype_pivot_pkg;
  localparam int WORD_W = 32;
  localparam int HALF_W = WORD_W / 2;

  typedef enum logic [3:0] {
    DT_S8 = 4'h2, DT_U8 = 4'h3, DT_S16 = 4'h4, DT_U16 = 4'h5,
    DT_BF16 = 4'h6, DT_F16 = 4'h7, DT_S32 = 4'h8, DT_U32 = 4'h9,
    DT_F32 = 4'hA, DT_F8E3 = 4'hD, DT_F8E4 = 4'hE, DT_F8E5 = 4'hF
  } dtype_e;

  localparam logic [31:0] F32_QNAN = 32'h7FC0_0000;

  // magnitude to FP32, RNE on bits beyond the 24-bit significand
  function automatic logic [31:0] int_to_f32(logic [31:0] mag, logic neg);
    logic [31:0] n, r;
    logic rnd;
    int p;
    if (mag == 32'd0) return 32'd0;
    p = 0;
    for (int i = 0; i < 32; i++) if (mag[i]) p = i;
    n = mag << (31 - p);
    rnd = n[7] & ((|n[6:0]) | n[8]);
    r = {1'b0, 8'(127 + p), n[30:8]} + {31'd0, rnd};
    return {neg, r[30:0]};
  endfunction

  function automatic logic [31:0] int_widen(logic [31:0] w0, int w, logic sgn);
    logic [31:0] msk, raw, mag;
    logic neg;
    msk = (32'd1 << w) - 32'd1;
    raw = w0 & msk;
    neg = sgn & raw[w-1];
    mag = neg ? ((~raw + 32'd1) & msk) : raw;
    return int_to_f32(mag, neg);
  endfunction

  // exact widening of a small float (exponent <= 5 bits)
  function automatic logic [31:0] small_widen(logic [15:0] x, int ew, int mw);
    logic s;
    logic [15:0] e, m, eall;
    logic [31:0] mm;
    int bias, k;
    s = x[ew+mw];
    eall = (16'd1 << ew) - 16'd1;
    e = (x >> mw) & eall;
    m = x & ((16'd1 << mw) - 16'd1);
    bias = (1 << (ew - 1)) - 1;
    if (e == eall) return (m != 16'd0) ? F32_QNAN : {s, 8'hFF, 23'd0};
    if (e == 16'd0) begin
      if (m == 16'd0) return {s, 31'd0};
      k = 0;
      for (int i = 0; i < 16; i++) if (i < mw && m[i]) k = i;
      mm = {16'd0, m} & ~(32'd1 << k);
      mm = mm << (23 - k);
      return {s, 8'(k + 1 - bias - mw + 127), mm[22:0]};
    end
    mm = {16'd0, m} << (23 - mw);
    return {s, 8'(int'(e) - bias + 127), mm[22:0]};
  endfunction

  // FP32 to a float of at most 16 bits, RNE, saturating overflow
  function automatic logic [15:0] small_narrow(logic [31:0] f, int ew, int mw, logic inf_sat);
    logic s, g, st, rnd;
    logic [31:0] sig, q, lim, maxf, res, gm, sb;
    int te, sh, bias;
    s = f[31];
    bias = (1 << (ew - 1)) - 1;
    lim = ((32'd1 << ew) - 32'd1) << mw;
    maxf = lim - 32'd1;
    if (f[30:23] == 8'hFF && f[22:0] != 23'd0) begin
      s = 1'b0;
      res = lim | (32'd1 << (mw - 1));
    end else if (f[30:23] == 8'hFF) begin
      res = inf_sat ? maxf : lim;
    end else begin
      sig = {8'd0, (f[30:23] != 8'd0), f[22:0]};
      te = ((f[30:23] == 8'd0) ? 1 : int'(f[30:23])) - 127 + bias;
      if (te >= (1 << ew) - 1) res = maxf;
      else begin
        sh = 23 - mw;
        if (te < 1) sh = sh + 1 - te;
        if (sh > 25) sh = 25;
        q = sig >> sh;
        g = sig[sh-1];
        gm = (32'd1 << (sh - 1)) - 32'd1;
        st = (sig & gm) != 32'd0;
        rnd = g & (st | q[0]);
        sb = (te >= 1) ? (32'(te - 1) << mw) : 32'd0;
        res = sb + q + {31'd0, rnd};
        if (res >= lim) res = maxf;
      end
    end
    res = res | ({31'd0, s} << (ew + mw));
    return res[15:0];
  endfunction

  // FP32 to integer, truncating, saturating, NaN -> 0
  function automatic logic [31:0] f32_to_int(logic [31:0] f, int w, logic sgn);
    logic [63:0] mag, lp, ln, r;
    logic big;
    int k;
    if (f[30:23] == 8'hFF && f[22:0] != 23'd0) return 32'd0;
    big = 1'b0;
    mag = 64'd0;
    if (f[30:23] >= 8'd127) begin
      k = int'(f[30:23]) - 127;
      if (k >= 32) big = 1'b1;
      else begin
        mag = {40'd0, 1'b1, f[22:0]};
        mag = (k >= 23) ? (mag << (k - 23)) : (mag >> (23 - k));
      end
    end
    lp = sgn ? ((64'd1 << (w - 1)) - 64'd1) : ((64'd1 << w) - 64'd1);
    ln = sgn ? (64'd1 << (w - 1)) : 64'd0;
    if (!f[31]) r = (big || mag > lp) ? lp : mag;
    else        r = (big || mag > ln) ? -ln : -mag;
    r = r & ((64'd1 << w) - 64'd1);
    return r[31:0];
  endfunction
endpackage

// File: rtl/dpc_widen.sv
module dpc_widen
  import dtype_pivot_pkg::*;
(
  input  logic [3:0]        type_i,
  input  logic [WORD_W-1:0] word_i,
  output logic [31:0]       f32_o
);
  always_comb begin
    case (type_i)
      DT_S8:   f32_o = int_widen(word_i, 8, 1'b1);
      DT_U8:   f32_o = int_widen(word_i, 8, 1'b0);
      DT_S16:  f32_o = int_widen(word_i, 16, 1'b1);
      DT_U16:  f32_o = int_widen(word_i, 16, 1'b0);
      DT_S32:  f32_o = int_widen(word_i, 32, 1'b1);
      DT_U32:  f32_o = int_widen(word_i, 32, 1'b0);
      DT_F16:  f32_o = small_widen(word_i[HALF_W-1:0], 5, 10);
      DT_F8E3: f32_o = small_widen({8'd0, word_i[7:0]}, 3, 4);
      DT_F8E4: f32_o = small_widen({8'd0, word_i[7:0]}, 4, 3);
      DT_F8E5: f32_o = small_widen({8'd0, word_i[7:0]}, 5, 2);
      DT_BF16: f32_o = (word_i[14:7] == 8'hFF && word_i[6:0] != 7'd0) ? F32_QNAN
                                                                      : {word_i[15:0], 16'd0};
      DT_F32:  f32_o = (word_i[30:23] == 8'hFF && word_i[22:0] != 23'd0) ? F32_QNAN : word_i;
      default: f32_o = 32'd0;
    endcase
  end
endmodule

// File: rtl/dpc_narrow.sv
module dpc_narrow
  import dtype_pivot_pkg::*;
(
  input  logic [3:0]        type_i,
  input  logic [31:0]       f32_i,
  output logic [WORD_W-1:0] word_o
);
  always_comb begin
    case (type_i)
      DT_S8:   word_o = f32_to_int(f32_i, 8, 1'b1);
      DT_U8:   word_o = f32_to_int(f32_i, 8, 1'b0);
      DT_S16:  word_o = f32_to_int(f32_i, 16, 1'b1);
      DT_U16:  word_o = f32_to_int(f32_i, 16, 1'b0);
      DT_S32:  word_o = f32_to_int(f32_i, 32, 1'b1);
      DT_U32:  word_o = f32_to_int(f32_i, 32, 1'b0);
      DT_BF16: word_o = {16'd0, small_narrow(f32_i, 8, 7, 1'b0)};
      DT_F16:  word_o = {16'd0, small_narrow(f32_i, 5, 10, 1'b0)};
      DT_F8E3: word_o = {16'd0, small_narrow(f32_i, 3, 4, 1'b1)};
      DT_F8E4: word_o = {16'd0, small_narrow(f32_i, 4, 3, 1'b1)};
      DT_F8E5: word_o = {16'd0, small_narrow(f32_i, 5, 2, 1'b1)};
      DT_F32:  word_o = f32_i;
      default: word_o = '0;
    endcase
  end
endmodule

// File: rtl/dtype_pivot_conv.sv
module dtype_pivot_conv
  import dtype_pivot_pkg::*;
(
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              valid_i,
  input  logic [3:0]        src_type_i,
  input  logic [3:0]        dst_type_i,
  input  logic [WORD_W-1:0] data_i,
  output logic              valid_o,
  output logic [WORD_W-1:0] data_o
);
  logic              a_vld, b_vld, b_byp;
  logic [3:0]        a_src, a_dst, b_dst;
  logic [WORD_W-1:0] a_word, b_word, nar_word;
  logic [31:0]       wid_f32, b_f32;

  dpc_widen u_widen (.type_i(a_src), .word_i(a_word), .f32_o(wid_f32));
  dpc_narrow u_narrow (.type_i(b_dst), .f32_i(b_f32), .word_o(nar_word));

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      a_vld <= 1'b0; a_src <= '0; a_dst <= '0; a_word <= '0;
      b_vld <= 1'b0; b_byp <= 1'b0; b_dst <= '0; b_word <= '0; b_f32 <= '0;
      valid_o <= 1'b0; data_o <= '0;
    end else begin
      a_vld  <= valid_i;
      a_src  <= src_type_i;
      a_dst  <= dst_type_i;
      a_word <= data_i;
      b_vld  <= a_vld;
      b_byp  <= (a_src == a_dst);
      b_dst  <= a_dst;
      b_word <= a_word;
      b_f32  <= wid_f32;
      valid_o <= b_vld;
      data_o  <= b_byp ? b_word : nar_word;
    end
  end
endmodule

// File: rtl/dtype_pivot_conv_chk.sv
module dtype_pivot_conv_chk (
  input logic        clk_i,
  input logic        rst_ni,
  input logic        valid_i,
  input logic [3:0]  src_type_i,
  input logic [3:0]  dst_type_i,
  input logic [31:0] data_i,
  input logic        valid_o,
  input logic [31:0] data_o
);
  logic [1:0] cyc;
  logic       warm;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) cyc <= 2'd0;
    else if (cyc != 2'd3) cyc <= cyc + 2'd1;
  end
  assign warm = (cyc == 2'd3);

  assert_latency_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    warm |-> (valid_o == $past(valid_i, 3)));

  assert_bypass_R3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (warm && valid_o && $past(valid_i && (src_type_i == dst_type_i), 3))
      |-> (data_o == $past(data_i, 3)));

  assert_nan_int_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (warm && valid_o && $past(valid_i && src_type_i == 4'hA && data_i[30:23] == 8'hFF &&
                              data_i[22:0] != 23'd0 && dst_type_i >= 4'h2 &&
                              dst_type_i <= 4'h9 && dst_type_i != 4'h6 && dst_type_i != 4'h7, 3))
      |-> (data_o == 32'd0));

  assert_f16_nan_R9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (warm && valid_o && $past(valid_i && src_type_i == 4'h7 && dst_type_i == 4'hA &&
                              data_i[14:10] == 5'h1F && data_i[9:0] != 10'd0, 3))
      |-> (data_o == 32'h7FC0_0000));

  assert_zext_R12: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (warm && valid_o && $past(valid_i && src_type_i != dst_type_i &&
                              (dst_type_i == 4'h2 || dst_type_i == 4'h3 || dst_type_i >= 4'hD), 3))
      |-> (data_o[31:8] == 24'd0));
endmodule

bind dtype_pivot_conv dtype_pivot_conv_chk u_chk (
  .clk_i(clk_i), .rst_ni(rst_ni), .valid_i(valid_i), .src_type_i(src_type_i),
  .dst_type_i(dst_type_i), .data_i(data_i), .valid_o(valid_o), .data_o(data_o)
);

// File: tb/sim_dtype_pivot_conv.sv
module sim_dtype_pivot_conv;
  logic        clk = 1'b0;
  logic        rst_ni = 1'b0;
  logic        valid_i = 1'b0;
  logic [3:0]  src_type_i = 4'h0;
  logic [3:0]  dst_type_i = 4'h0;
  logic [31:0] data_i = 32'd0;
  logic        valid_o;
  logic [31:0] data_o;
  int checks = 0;
  int errors = 0;
  bit done = 1'b0;

  always #5 clk = ~clk;

  dtype_pivot_conv u0 (
    .clk_i(clk), .rst_ni(rst_ni), .valid_i(valid_i), .src_type_i(src_type_i),
    .dst_type_i(dst_type_i), .data_i(data_i), .valid_o(valid_o), .data_o(data_o)
  );

  typedef struct packed {
    logic [7:0]  rq;
    logic [3:0]  src;
    logic [3:0]  dst;
    logic [31:0] din;
    logic [31:0] exp;
  } vec_t;

  localparam int NV = 63;
  localparam vec_t TBL [NV] = '{
    // R1 format layouts
    '{8'd1, 4'hD, 4'hA, 32'h30, 32'h3F800000},
    '{8'd1, 4'hE, 4'hA, 32'h30, 32'h3F000000},
    '{8'd1, 4'hF, 4'hA, 32'h30, 32'h3E000000},
    '{8'd1, 4'h6, 4'hA, 32'h3F80, 32'h3F800000},
    // R3 equal codes
    '{8'd3, 4'h7, 4'h7, 32'h7D01, 32'h7D01},
    '{8'd3, 4'h2, 4'h2, 32'hFF, 32'hFF},
    '{8'd3, 4'hA, 4'hA, 32'h7F800001, 32'h7F800001},
    '{8'd3, 4'hF, 4'hF, 32'h7F, 32'h7F},
    // R4 integer sources
    '{8'd4, 4'h8, 4'hA, 32'h01000001, 32'h4B800000},
    '{8'd4, 4'h8, 4'hA, 32'h01000003, 32'h4B800002},
    '{8'd4, 4'h9, 4'hA, 32'hFFFFFFFF, 32'h4F800000},
    '{8'd4, 4'h8, 4'hA, 32'h80000000, 32'hCF000000},
    '{8'd4, 4'h2, 4'h7, 32'h80, 32'hD800},
    '{8'd4, 4'h3, 4'h6, 32'hFF, 32'h437F},
    '{8'd4, 4'h4, 4'hF, 32'h7FFF, 32'h78},
    // R5 truncation
    '{8'd5, 4'hA, 4'h2, 32'hC02CCCCD, 32'hFE},
    '{8'd5, 4'hA, 4'h3, 32'h4039999A, 32'h02},
    '{8'd5, 4'h7, 4'h8, 32'hB800, 32'h0},
    '{8'd5, 4'hA, 4'h4, 32'hC0F00000, 32'hFFF9},
    // R6 integer saturation
    '{8'd6, 4'hA, 4'h2, 32'h43960000, 32'h7F},
    '{8'd6, 4'hA, 4'h3, 32'h43960000, 32'hFF},
    '{8'd6, 4'hA, 4'h2, 32'hC3960000, 32'h80},
    '{8'd6, 4'hA, 4'h5, 32'hBF800000, 32'h0},
    '{8'd6, 4'hA, 4'h8, 32'h7FC00000, 32'h0},
    '{8'd6, 4'hA, 4'h9, 32'h7F800000, 32'hFFFFFFFF},
    '{8'd6, 4'hA, 4'h8, 32'h4F32D05E, 32'h7FFFFFFF},
    '{8'd6, 4'hA, 4'h8, 32'hCF000000, 32'h80000000},
    '{8'd6, 4'h7, 4'h3, 32'hFC00, 32'h0},
    // R7 ties to even
    '{8'd7, 4'hA, 4'h7, 32'h3F801000, 32'h3C00},
    '{8'd7, 4'hA, 4'h7, 32'h3F803000, 32'h3C02},
    '{8'd7, 4'hA, 4'h6, 32'h3F808000, 32'h3F80},
    '{8'd7, 4'hA, 4'h6, 32'h3F818000, 32'h3F82},
    '{8'd7, 4'hA, 4'hE, 32'h3F880000, 32'h38},
    // R8 float overflow
    '{8'd8, 4'hA, 4'h7, 32'h49742400, 32'h7BFF},
    '{8'd8, 4'hA, 4'h7, 32'h477FF000, 32'h7BFF},
    '{8'd8, 4'hA, 4'h7, 32'h7F800000, 32'h7C00},
    '{8'd8, 4'hA, 4'hE, 32'hFF800000, 32'hF7},
    '{8'd8, 4'hA, 4'hF, 32'h49742400, 32'h7B},
    '{8'd8, 4'hA, 4'hD, 32'hC9742400, 32'hEF},
    // R9 canonical NaN
    '{8'd9, 4'hA, 4'h7, 32'hFFFFFFFF, 32'h7E00},
    '{8'd9, 4'h6, 4'hA, 32'hFFC1, 32'h7FC00000},
    '{8'd9, 4'h7, 4'hE, 32'h7C01, 32'h7C},
    '{8'd9, 4'hF, 4'h6, 32'h7F, 32'h7FC0},
    '{8'd9, 4'hD, 4'hF, 32'h79, 32'h7E},
    '{8'd9, 4'hA, 4'hD, 32'h7FC00000, 32'h78},
    // R10 subnormals and underflow
    '{8'd10, 4'h7, 4'hA, 32'h0001, 32'h33800000},
    '{8'd10, 4'hA, 4'h7, 32'h33800000, 32'h0001},
    '{8'd10, 4'hA, 4'h7, 32'h80000001, 32'h8000},
    '{8'd10, 4'hA, 4'h6, 32'h00000001, 32'h0000},
    '{8'd10, 4'hA, 4'h6, 32'h00018000, 32'h0002},
    '{8'd10, 4'hE, 4'hA, 32'h01, 32'h3B000000},
    '{8'd10, 4'hA, 4'hE, 32'h3A800000, 32'h00},
    '{8'd10, 4'hA, 4'hE, 32'h3AC00000, 32'h01},
    // R11 float to float through the pivot
    '{8'd11, 4'h6, 4'h7, 32'h3F81, 32'h3C08},
    '{8'd11, 4'hE, 4'h7, 32'h38, 32'h3C00},
    '{8'd11, 4'hF, 4'h7, 32'h3C, 32'h3C00},
    '{8'd11, 4'h7, 4'hF, 32'h3C01, 32'h3C},
    '{8'd11, 4'h6, 4'hD, 32'h4049, 32'h49},
    // R12 zero extension
    '{8'd12, 4'h2, 4'h4, 32'hFF, 32'hFFFF},
    '{8'd12, 4'h4, 4'h2, 32'hFFFE, 32'hFE},
    '{8'd12, 4'hA, 4'hE, 32'hBF800000, 32'hB8},
    '{8'd12, 4'h5, 4'h8, 32'hFFFF, 32'hFFFF},
    '{8'd12, 4'h2, 4'h4, 32'hFFFFFF85, 32'hFF85}
  };

  task automatic chk(input int rq, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL R%0d actual=%08h expected=%08h", rq, act, exp);
    end
  endtask

  task automatic finish_run();
    if (!done) begin
      done = 1'b1;
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  endtask

  initial begin
    #1_000_000;
    checks++;
    errors++;
    $display("FAIL R2 watchdog expired actual=hung expected=done");
    finish_run();
  end

  initial begin
    // R2 reset state
    #12;
    chk(2, {31'd0, valid_o}, 32'd0);
    chk(2, data_o, 32'd0);
    @(negedge clk);
    rst_ni = 1'b1;
    repeat (2) @(negedge clk);

    // table streamed one row per cycle
    for (int t = 0; t < NV + 3; t++) begin
      @(negedge clk);
      if (t >= 3) begin
        chk(2, {31'd0, valid_o}, 32'd1);
        chk(int'(TBL[t-3].rq), data_o, TBL[t-3].exp);
      end
      if (t < NV) begin
        valid_i = 1'b1;
        src_type_i = TBL[t].src;
        dst_type_i = TBL[t].dst;
        data_i = TBL[t].din;
      end else begin
        valid_i = 1'b0;
      end
    end

    // R2 single pulse: exactly one valid_o, three edges later
    @(negedge clk);
    valid_i = 1'b1; src_type_i = 4'hA; dst_type_i = 4'h7; data_i = 32'h3F800000;
    @(negedge clk);
    valid_i = 1'b0; data_i = 32'h49742400;
    chk(2, {31'd0, valid_o}, 32'd0);
    for (int i = 2; i <= 6; i++) begin
      @(negedge clk);
      chk(2, {31'd0, valid_o}, (i == 3) ? 32'd1 : 32'd0);
      if (i == 3) chk(7, data_o, 32'h3C00);
    end

    // R2 reset in flight clears outputs and flushes the pipe
    @(negedge clk);
    valid_i = 1'b1; src_type_i = 4'h2; dst_type_i = 4'h2; data_i = 32'h5A;
    @(negedge clk);
    @(negedge clk);
    valid_i = 1'b0;
    rst_ni = 1'b0;
    #1;
    chk(2, {31'd0, valid_o}, 32'd0);
    chk(2, data_o, 32'd0);
    @(negedge clk);
    rst_ni = 1'b1;
    repeat (4) begin
      @(negedge clk);
      chk(2, {31'd0, valid_o}, 32'd0);
    end

    finish_run();
  end
endmodule